// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block stores one accepted receive frame into host memory by walking a ring of 16-byte descriptors. Each descriptor is owned either by hardware or by software. For every segment the block reads the descriptor's status, control and buffer-address words. It checks that hardware owns the descriptor and that the buffer address is allowed. It then streams up to the buffer size of frame bytes into the buffer as little-endian 32-bit words. It writes the status word back with ownership released. Finally it steps its ring index, which returns to zero after any descriptor whose end flag is set.

Frame bytes arrive on a valid/ready byte stream. A last marker goes with the final byte, and broadcast and multicast tags are held for the whole frame. Memory is reached through a single-word request port: request, write, address, write data, byte enables, read data and ready. A request is complete in the cycle in which ready is high. Four one-cycle event outputs report the outcome of the frame for an interrupt status register further up.

Top module: `rxr_ring_writer`

## Requirements
- R1: While either of cfg_rx_en and cfg_dma_en is low and no frame is in progress, frm_ready stays low, no memory request is made, and a waiting frame is held untouched.
- R2: The descriptor for ring index i starts at byte address ring_base + 16*i. Its status word is read at offset 0, its control word at offset 4 and its buffer address at offset 8. A request holds its address until ready is seen.
- R3: If the status word has bit 31 clear (owned by software), ev_no_buf pulses and the rest of the frame is consumed and discarded. Nothing is written to memory and rx_idx is unchanged.
- R4: A buffer address is valid only when its bits 1:0 equal 2'b10. Any other value pulses ev_align_err and discards the rest of the frame. Nothing is written for that segment and rx_idx is unchanged.
- R5: Each segment holds min(remaining frame bytes, buffer size) bytes, where the buffer size is control-word bits 10:0. A longer frame continues in the next descriptor.
- R6: The status word written back has bit 31 = 0, bit 29 = first segment, bit 28 = last segment, bit 17 = broadcast tag, bit 16 = multicast tag, bits 10:0 = bytes in this segment, and every other bit 0. A frame that exactly fills a buffer marks that segment as last.
- R7: After each write-back, rx_idx becomes 0 if control-word bit 31 (ring end) was set, and otherwise rx_idx + 1.
- R8: Byte k of a segment goes to byte address buffer + k. Within a 32-bit word, byte lane n holds address bits 1:0 = n. Only the written lanes have their byte enables set, so neighbouring bytes keep their contents.
- R9: After the last segment's write-back, ev_rx_ok and ev_rx_done pulse together for one cycle. At most one of ev_rx_done, ev_no_buf and ev_align_err is high in any cycle.
- R10: After reset, rx_idx is 0, no memory request is made, frm_ready is low and all event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rx_en | input | 1 | Receive enable |
| cfg_dma_en | input | 1 | Receive DMA enable |
| ring_base | input | AW | Byte address of descriptor 0 |
| frm_valid | input | 1 | Frame byte valid |
| frm_ready | output | 1 | Frame byte accepted this cycle when valid |
| frm_data | input | 8 | Frame byte |
| frm_last | input | 1 | Marks the final byte of the frame |
| frm_bcast | input | 1 | Frame is broadcast, held for the frame |
| frm_mcast | input | 1 | Frame is multicast, held for the frame |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables for writes |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Request completes this cycle |
| rx_idx | output | IDX_W | Current ring index |
| ev_rx_ok | output | 1 | Frame stored |
| ev_rx_done | output | 1 | Frame finished |
| ev_no_buf | output | 1 | Descriptor not owned by hardware |
| ev_align_err | output | 1 | Buffer address not allowed |

## Verification
The bench builds the block with IDX_W = 4, a 32-bit address and an 11-bit length field. The ring has three descriptors, and the end flag set on the third one makes the index return to zero after a few frames. Buffer sizes of 3 and 4 bytes split a 9-byte frame over three descriptors, including a segment that ends in the middle of a word. A 4-byte frame in a 4-byte buffer reaches the exact-fit last-segment case. A run with a ready that toggles every cycle and a moved ring base checks that requests are held and that descriptor addresses are computed.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int DW          = 32;
    localparam int DESC_SHIFT  = 4;

    localparam int W0_OWN      = 31;
    localparam int W0_FIRST    = 29;
    localparam int W0_LAST     = 28;
    localparam int W0_BCAST    = 17;
    localparam int W0_MCAST    = 16;
    localparam int W1_END      = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_RD_CTRL,
        ST_RD_BUF,
        ST_FILL,
        ST_WR_DATA,
        ST_WR_STAT,
        ST_DRAIN
    } rxr_state_e;

    typedef struct packed {
        logic bcast;
        logic mcast;
        logic first;
        logic wrap;
    } seg_flags_t;

    function automatic logic buf_addr_ok(input logic [1:0] lo);
        return lo == 2'b10;
    endfunction

endpackage

// File: rtl/rxr_lane_packer.sv
module rxr_lane_packer #(
    parameter int BYTES = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic [$clog2(BYTES)-1:0]   lane,
    input  logic [7:0]                 din,
    input  logic                       clear,
    output logic [8*BYTES-1:0]         word,
    output logic [BYTES-1:0]           be
);
    localparam int LANE_W = $clog2(BYTES);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [7:0] byte_q;
        logic       en_q;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                byte_q <= '0;
                en_q   <= 1'b0;
            end else if (load && lane == LANE_W'(g)) begin
                byte_q <= din;
                en_q   <= 1'b1;
            end
        end
        assign word[8*g +: 8] = byte_q;
        assign be[g]          = en_q;
    end

endmodule

// File: rtl/rxr_ring_index.sv
module rxr_ring_index #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (step) begin
            idx <= wrap ? '0 : idx + IDX_W'(1);
        end
    end
endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int AW    = 32,
    parameter int IDX_W = 8,
    parameter int LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_rx_en,
    input  logic             cfg_dma_en,
    input  logic [AW-1:0]    ring_base,
    input  logic             frm_valid,
    output logic             frm_ready,
    input  logic [7:0]       frm_data,
    input  logic             frm_last,
    input  logic             frm_bcast,
    input  logic             frm_mcast,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic [DW/8-1:0]  mem_be,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ready,
    output logic [IDX_W-1:0] rx_idx,
    output logic             ev_rx_ok,
    output logic             ev_rx_done,
    output logic             ev_no_buf,
    output logic             ev_align_err
);
    localparam int BE_W = DW / 8;

    rxr_state_e  state;
    seg_flags_t  flags;
    logic [LEN_W-1:0] seg_bufsz;
    logic [LEN_W-1:0] seg_cnt;
    logic [AW-1:0]    cur_addr;
    logic [AW-1:0]    word_addr;
    logic             seg_full;
    logic             frame_end;

    logic [AW-1:0]    desc_addr;
    logic [DW-1:0]    stat_word;
    logic [DW-1:0]    pk_word;
    logic [BE_W-1:0]  pk_be;
    logic             take;
    logic             pk_clear;
    logic             idx_step;
    logic             enabled;
    logic             seg_hit;

    assign enabled   = cfg_rx_en && cfg_dma_en;
    assign desc_addr = ring_base + (AW'(rx_idx) << DESC_SHIFT);
    assign take      = (state == ST_FILL) && frm_valid;
    assign pk_clear  = (state == ST_WR_DATA) && mem_ready;
    assign idx_step  = (state == ST_WR_STAT) && mem_ready;
    assign seg_hit   = (seg_cnt + LEN_W'(1)) == seg_bufsz;

    rxr_lane_packer #(.BYTES(BE_W)) u_packer (
        .clk   (clk),
        .rst   (rst),
        .load  (take),
        .lane  (cur_addr[$clog2(BE_W)-1:0]),
        .din   (frm_data),
        .clear (pk_clear),
        .word  (pk_word),
        .be    (pk_be)
    );

    rxr_ring_index #(.IDX_W(IDX_W)) u_index (
        .clk  (clk),
        .rst  (rst),
        .step (idx_step),
        .wrap (flags.wrap),
        .idx  (rx_idx)
    );

    always_comb begin
        stat_word            = '0;
        stat_word[W0_FIRST]  = flags.first;
        stat_word[W0_LAST]   = frame_end;
        stat_word[W0_BCAST]  = flags.bcast;
        stat_word[W0_MCAST]  = flags.mcast;
        stat_word[LEN_W-1:0] = seg_cnt;
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        mem_be    = '1;
        frm_ready = 1'b0;
        case (state)
            ST_RD_STAT: mem_req = 1'b1;
            ST_RD_CTRL: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + AW'(4);
            end
            ST_RD_BUF: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + AW'(8);
            end
            ST_FILL:  frm_ready = 1'b1;
            ST_WR_DATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = word_addr;
                mem_wdata = pk_word;
                mem_be    = pk_be;
            end
            ST_WR_STAT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = stat_word;
            end
            ST_DRAIN: frm_ready = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            flags        <= '0;
            seg_bufsz    <= '0;
            seg_cnt      <= '0;
            cur_addr     <= '0;
            word_addr    <= '0;
            seg_full     <= 1'b0;
            frame_end    <= 1'b0;
            ev_rx_ok     <= 1'b0;
            ev_rx_done   <= 1'b0;
            ev_no_buf    <= 1'b0;
            ev_align_err <= 1'b0;
        end else begin
            ev_rx_ok     <= 1'b0;
            ev_rx_done   <= 1'b0;
            ev_no_buf    <= 1'b0;
            ev_align_err <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (enabled && frm_valid) begin
                        flags.bcast <= frm_bcast;
                        flags.mcast <= frm_mcast;
                        flags.first <= 1'b1;
                        state       <= ST_RD_STAT;
                    end
                end
                ST_RD_STAT: begin
                    if (mem_ready) begin
                        if (mem_rdata[W0_OWN]) begin
                            state <= ST_RD_CTRL;
                        end else begin
                            ev_no_buf <= 1'b1;
                            state     <= ST_DRAIN;
                        end
                    end
                end
                ST_RD_CTRL: begin
                    if (mem_ready) begin
                        seg_bufsz  <= mem_rdata[LEN_W-1:0];
                        flags.wrap <= mem_rdata[W1_END];
                        state      <= ST_RD_BUF;
                    end
                end
                ST_RD_BUF: begin
                    if (mem_ready) begin
                        if (buf_addr_ok(mem_rdata[1:0])) begin
                            cur_addr <= AW'(mem_rdata);
                            seg_cnt  <= '0;
                            state    <= ST_FILL;
                        end else begin
                            ev_align_err <= 1'b1;
                            state        <= ST_DRAIN;
                        end
                    end
                end
                ST_FILL: begin
                    if (frm_valid) begin
                        cur_addr  <= cur_addr + AW'(1);
                        word_addr <= {cur_addr[AW-1:2], 2'b00};
                        seg_cnt   <= seg_cnt + LEN_W'(1);
                        if (cur_addr[1:0] == 2'b11 || seg_hit || frm_last) begin
                            seg_full  <= seg_hit || frm_last;
                            frame_end <= frm_last;
                            state     <= ST_WR_DATA;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (mem_ready) begin
                        state <= seg_full ? ST_WR_STAT : ST_FILL;
                    end
                end
                ST_WR_STAT: begin
                    if (mem_ready) begin
                        if (frame_end) begin
                            ev_rx_ok   <= 1'b1;
                            ev_rx_done <= 1'b1;
                            state      <= ST_IDLE;
                        end else begin
                            flags.first <= 1'b0;
                            state       <= ST_RD_STAT;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (frm_valid && frm_last) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_GATED_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!enabled && state == ST_IDLE) |-> (!mem_req && !frm_ready)); // R1
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R2
    AST_SEG_WITHIN_BUF: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WR_STAT) |-> (seg_cnt <= seg_bufsz)); // R5
    AST_WB_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_addr == desc_addr) |-> !mem_wdata[W0_OWN]); // R6
    AST_WRITE_HAS_LANES: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_be != '0)); // R8
    AST_EVENTS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_rx_done, ev_no_buf, ev_align_err})); // R9
    AST_OK_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        ev_rx_done |-> ev_rx_ok); // R9

endmodule

// File: tb/rxr_ring_writer_bench.sv
`timescale 1ns/1ps
module rxr_ring_writer_bench;
    localparam int AW    = 32;
    localparam int IDX_W = 4;
    localparam int LEN_W = 11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_rx_en = 1'b0;
    logic             cfg_dma_en = 1'b0;
    logic [AW-1:0]    ring_base = 32'h100;
    logic             frm_valid = 1'b0;
    logic             frm_ready;
    logic [7:0]       frm_data = '0;
    logic             frm_last = 1'b0;
    logic             frm_bcast = 1'b0;
    logic             frm_mcast = 1'b0;
    logic             mem_req;
    logic             mem_we;
    logic [AW-1:0]    mem_addr;
    logic [31:0]      mem_wdata;
    logic [3:0]       mem_be;
    logic [31:0]      mem_rdata;
    logic             mem_ready;
    logic [IDX_W-1:0] rx_idx;
    logic             ev_rx_ok, ev_rx_done, ev_no_buf, ev_align_err;

    logic [31:0] mem [0:1023];
    logic stall_mode = 1'b0;
    logic tgl = 1'b0;
    int n_chk = 0, n_err = 0;
    int req_cnt = 0, wr_cnt = 0;
    int ok_cnt = 0, done_cnt = 0, nobuf_cnt = 0, align_cnt = 0;

    always #4 clk = ~clk;
    always @(negedge clk) tgl <= ~tgl;
    assign mem_ready = !stall_mode || tgl;
    assign mem_rdata = mem[mem_addr[11:2]];

    rxr_ring_writer #(.AW(AW), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_rxr_ring_writer (
        .clk(clk), .rst(rst), .cfg_rx_en(cfg_rx_en), .cfg_dma_en(cfg_dma_en),
        .ring_base(ring_base), .frm_valid(frm_valid), .frm_ready(frm_ready),
        .frm_data(frm_data), .frm_last(frm_last), .frm_bcast(frm_bcast),
        .frm_mcast(frm_mcast), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rx_idx(rx_idx),
        .ev_rx_ok(ev_rx_ok), .ev_rx_done(ev_rx_done), .ev_no_buf(ev_no_buf),
        .ev_align_err(ev_align_err)
    );

    always @(posedge clk) begin
        if (!rst) begin
            if (mem_req) req_cnt++;
            if (mem_req && mem_we && mem_ready) begin
                wr_cnt++;
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] = mem_wdata[8*b +: 8];
            end
            if (ev_rx_ok)     ok_cnt++;
            if (ev_rx_done)   done_cnt++;
            if (ev_no_buf)    nobuf_cnt++;
            if (ev_align_err) align_cnt++;
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_at(input logic [31:0] a);
        return mem[a[11:2]][8*a[1:0] +: 8];
    endfunction

    function automatic int ev_total();
        return done_cnt + nobuf_cnt + align_cnt;
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic own, input logic [10:0] bsz,
                            input logic endf, input logic [31:0] bufa);
        mem[a[11:2]]     = {own, 31'd0};
        mem[a[11:2] + 1] = {endf, 20'd0, bsz};
        mem[a[11:2] + 2] = bufa;
        mem[a[11:2] + 3] = '0;
    endtask

    task automatic send_frame(input int len, input logic [7:0] seed, input logic bc, input logic mc);
        frm_bcast = bc;
        frm_mcast = mc;
        for (int i = 0; i < len; i++) begin
            frm_valid = 1'b1;
            frm_data  = seed + 8'(i);
            frm_last  = (i == len - 1);
            while (!frm_ready) @(negedge clk);
            @(negedge clk);
        end
        frm_valid = 1'b0;
        frm_last  = 1'b0;
    endtask

    task automatic wait_event(input int prev);
        int k = 0;
        while (ev_total() == prev && k < 1000) begin
            @(negedge clk);
            k++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_bytes(input string req, input logic [31:0] a, input int len, input logic [7:0] seed);
        for (int i = 0; i < len; i++)
            chk(req, "buffer byte", 32'(byte_at(a + 32'(i))), 32'(seed + 8'(i)));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10", "rx_idx after reset", 32'(rx_idx), 0);
        chk("R10", "mem_req after reset", 32'(mem_req), 0);
        chk("R10", "frm_ready after reset", 32'(frm_ready), 0);
        chk("R10", "events after reset", 32'({ev_rx_ok, ev_rx_done, ev_no_buf, ev_align_err}), 0);
    endtask

    task automatic t_gate_and_single();
        int prev, r0, seen;
        put_desc(32'h100, 1'b1, 11'd64, 1'b0, 32'h402);
        mem[32'h400 >> 2] = 32'hA5A5A5A5;
        cfg_rx_en = 1'b1; cfg_dma_en = 1'b0;
        frm_bcast = 1'b1; frm_valid = 1'b1; frm_data = 8'h10;
        r0 = req_cnt; seen = 0;
        repeat (8) begin
            @(negedge clk);
            if (frm_ready) seen++;
        end
        chk("R1", "frm_ready while DMA off", 32'(seen), 0);
        chk("R1", "requests while DMA off", 32'(req_cnt - r0), 0);
        cfg_dma_en = 1'b1;
        prev = ev_total();
        send_frame(10, 8'h10, 1'b1, 1'b0);
        wait_event(prev);
        chk_bytes("R8", 32'h402, 10, 8'h10);
        chk("R8", "lane 0 before buffer", 32'(byte_at(32'h400)), 32'hA5);
        chk("R8", "lane 1 before buffer", 32'(byte_at(32'h401)), 32'hA5);
        chk("R6", "single-segment status", mem[32'h100 >> 2], 32'h3002000A);
        chk("R7", "index after one descriptor", 32'(rx_idx), 1);
        chk("R9", "rx ok count", 32'(ok_cnt), 1);
        chk("R9", "rx done count", 32'(done_cnt), 1);
    endtask

    task automatic t_multi_segment();
        int prev;
        put_desc(32'h110, 1'b1, 11'd4, 1'b0, 32'h502);
        put_desc(32'h120, 1'b1, 11'd3, 1'b1, 32'h602);
        put_desc(32'h100, 1'b1, 11'd64, 1'b0, 32'h402);
        mem[32'h604 >> 2] = 32'hA5A5A5A5;
        prev = ev_total();
        send_frame(9, 8'h40, 1'b0, 1'b1);
        wait_event(prev);
        chk_bytes("R5", 32'h502, 4, 8'h40);
        chk_bytes("R5", 32'h602, 3, 8'h44);
        chk_bytes("R5", 32'h402, 2, 8'h47);
        chk("R8", "byte after short buffer", 32'(byte_at(32'h605)), 32'hA5);
        chk("R6", "first segment status", mem[32'h110 >> 2], 32'h20010004);
        chk("R6", "middle segment status", mem[32'h120 >> 2], 32'h00010003);
        chk("R6", "last segment status", mem[32'h100 >> 2], 32'h10010002);
        chk("R7", "index after end-flag wrap", 32'(rx_idx), 1);
        chk("R9", "done count after split frame", 32'(done_cnt), 2);
    endtask

    task automatic t_exact_fit();
        int prev;
        put_desc(32'h110, 1'b1, 11'd4, 1'b0, 32'h502);
        prev = ev_total();
        send_frame(4, 8'h80, 1'b0, 1'b0);
        wait_event(prev);
        chk_bytes("R5", 32'h502, 4, 8'h80);
        chk("R6", "exact-fit status", mem[32'h110 >> 2], 32'h30000004);
        chk("R7", "index after exact fit", 32'(rx_idx), 2);
    endtask

    task automatic t_not_owned();
        int prev, w0;
        put_desc(32'h120, 1'b0, 11'd3, 1'b1, 32'h602);
        w0 = wr_cnt;
        prev = ev_total();
        send_frame(5, 8'h90, 1'b0, 1'b0);
        wait_event(prev);
        chk("R3", "no-buffer events", 32'(nobuf_cnt), 1);
        chk("R3", "writes on unowned descriptor", 32'(wr_cnt - w0), 0);
        chk("R3", "index kept", 32'(rx_idx), 2);
        chk("R3", "done count unchanged", 32'(done_cnt), 3);
    endtask

    task automatic t_misaligned();
        int prev, w0;
        put_desc(32'h120, 1'b1, 11'd3, 1'b1, 32'h604);
        w0 = wr_cnt;
        prev = ev_total();
        send_frame(3, 8'hA0, 1'b0, 1'b0);
        wait_event(prev);
        chk("R4", "align error on 4-aligned buffer", 32'(align_cnt), 1);
        put_desc(32'h120, 1'b1, 11'd3, 1'b1, 32'h603);
        prev = ev_total();
        send_frame(3, 8'hA0, 1'b0, 1'b0);
        wait_event(prev);
        chk("R4", "align error on odd buffer", 32'(align_cnt), 2);
        chk("R4", "writes on bad buffer", 32'(wr_cnt - w0), 0);
        chk("R4", "descriptor still owned", mem[32'h120 >> 2], 32'h80000000);
        chk("R4", "index kept", 32'(rx_idx), 2);
    endtask

    task automatic t_stall_base();
        int prev;
        ring_base = 32'h200;
        put_desc(32'h220, 1'b1, 11'd64, 1'b1, 32'h702);
        stall_mode = 1'b1;
        prev = ev_total();
        send_frame(6, 8'hC0, 1'b0, 1'b0);
        wait_event(prev);
        stall_mode = 1'b0;
        chk_bytes("R2", 32'h702, 6, 8'hC0);
        chk("R2", "status at moved base", mem[32'h220 >> 2], 32'h30000006);
        chk("R2", "old ring untouched", mem[32'h120 >> 2], 32'h80000000);
        chk("R7", "index wraps on end flag", 32'(rx_idx), 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_gate_and_single();
        t_multi_segment();
        t_exact_fit();
        t_not_owned();
        t_misaligned();
        t_stall_base();
        finish_run();
    end
endmodule